// File: doc/BRIEF.md
# Masked Content-Addressable Translation Buffer

This block is a small translation buffer that maps a virtual page number to a physical frame number. A lookup presents a page number and a page offset. The page number is compared against every stored entry in the same cycle. A programmable mask register decides which page-number bits take part in that compare. The block registers one match flag per entry. One clock later it reports the following:

- whether the lookup hit or missed;
- the index and frame number of the winning entry;
- the entry's present and dirty bits;
- the physical address, formed by joining the frame number with the page offset.

A miss raises a walk-request output. That output means a page-table lookup is needed. It does not mean a page fault.

Entries are loaded through a fill port after a miss. A fill takes the lowest-indexed invalid entry. Once every entry is valid, a round-robin victim pointer chooses which entry a fill replaces. A lookup flagged as a store sets the dirty bit of the entry it hits.

Top module: `masked_xlat_cam`

## Requirements
- R1: After reset, all entries are invalid, the mask is all ones, and `res_valid`/`res_hit` are 0. The first lookup after reset misses.
- R2: A lookup sampled on `lookup_valid` at one rising edge produces results, with `res_valid` = 1, during the following cycle. `res_valid` is 0 in cycles without a preceding lookup.
- R3: An entry matches when it is valid and `(lookup_page & mask) == (stored page & mask)`. Page bits where the mask is 0 have no effect on the result. The mask is loaded from `mask_wdata` when `mask_we` is 1.
- R4: On a hit, the outputs are as follows:
  - `res_frame` gives the stored frame;
  - `res_paddr` equals `{frame, offset}`, with the frame in the upper `FRAME_W` bits;
  - `res_present` and `res_dirty` give the entry's bits.
- R5: On a miss, the outputs are as follows:
  - `res_hit` = 0 and `res_walk` = 1;
  - `res_frame`, `res_paddr`, `res_present` and `res_dirty` are 0.
- R6: When several entries match, the lowest-indexed one wins, and `res_index` gives its index.
- R7: A fill writes page, frame, present and dirty into the lowest-indexed invalid entry.
- R8: When all entries are valid, a fill replaces the entry at the victim pointer. The pointer starts at 0 after reset and advances by one, wrapping, after each such fill.
- R9: A store lookup that hits sets the winning entry's dirty bit on the same edge, so `res_dirty` is already 1 for that lookup. A store lookup that misses changes no entry.
- R10: A hit on an entry whose present bit is 0 is still reported as a hit, with `res_present` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mask_we | input | 1 | Load the compare mask |
| mask_wdata | input | PAGE_W | New mask value; a 1 bit takes part in the compare |
| lookup_valid | input | 1 | Start a lookup this cycle |
| lookup_page | input | PAGE_W | Page number to search for |
| lookup_offset | input | OFFS_W | Page offset carried to the physical address |
| lookup_store | input | 1 | The lookup is a store; a hit marks the entry dirty |
| fill_valid | input | 1 | Write a new entry this cycle |
| fill_page | input | PAGE_W | Page number of the new entry |
| fill_frame | input | FRAME_W | Frame number of the new entry |
| fill_present | input | 1 | Present bit of the new entry |
| fill_dirty | input | 1 | Dirty bit of the new entry |
| res_valid | output | 1 | Lookup result is valid this cycle |
| res_hit | output | 1 | Lookup hit |
| res_walk | output | 1 | Lookup missed; a page-table lookup is needed |
| res_index | output | IDX_W | Index of the winning entry |
| res_frame | output | FRAME_W | Frame number of the winning entry |
| res_paddr | output | FRAME_W+OFFS_W | Physical address {frame, offset} |
| res_present | output | 1 | Present bit of the winning entry |
| res_dirty | output | 1 | Dirty bit of the winning entry |

## Verification
The hardest state to reach is a lookup that matches several entries at once. With a full-width mask, distinct pages never collide. The stimulus therefore loads two entries whose pages differ only in their low bits, then narrows the mask so that both match a single key. The bench then checks that the lower index wins.

Victim replacement also needs setup. Every entry must first be filled, and each later fill must then be traced through lookups that show which old page disappeared.

// File: rtl/masked_xlat_cam.sv
module masked_xlat_cam #(
  parameter int ENTRIES = 4,
  parameter int PAGE_W  = 12,
  parameter int FRAME_W = 10,
  parameter int OFFS_W  = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int PA_W   = FRAME_W + OFFS_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mask_we,
  input  logic [PAGE_W-1:0]  mask_wdata,
  input  logic               lookup_valid,
  input  logic [PAGE_W-1:0]  lookup_page,
  input  logic [OFFS_W-1:0]  lookup_offset,
  input  logic               lookup_store,
  input  logic               fill_valid,
  input  logic [PAGE_W-1:0]  fill_page,
  input  logic [FRAME_W-1:0] fill_frame,
  input  logic               fill_present,
  input  logic               fill_dirty,
  output logic               res_valid,
  output logic               res_hit,
  output logic               res_walk,
  output logic [IDX_W-1:0]   res_index,
  output logic [FRAME_W-1:0] res_frame,
  output logic [PA_W-1:0]    res_paddr,
  output logic               res_present,
  output logic               res_dirty
);

  logic [PAGE_W-1:0]  mask_q;
  logic [PAGE_W-1:0]  tag_q   [ENTRIES];
  logic [FRAME_W-1:0] frame_q [ENTRIES];
  logic [ENTRIES-1:0] valid_q, pres_q, dirty_q;
  logic [ENTRIES-1:0] match_now, match_q;
  logic [IDX_W-1:0]   vict_q;
  logic [OFFS_W-1:0]  off_q;
  logic               rvalid_q;

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_cmp
      assign match_now[g] = valid_q[g] &&
                            ((lookup_page & mask_q) == (tag_q[g] & mask_q));
    end
  endgenerate

  logic [IDX_W-1:0] hit_idx_now, win_idx, free_idx, fill_idx;
  logic             hit_now, any_free;

  always_comb begin
    hit_idx_now = '0;
    win_idx     = '0;
    free_idx    = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match_now[i]) hit_idx_now = IDX_W'(i);
      if (match_q[i])   win_idx     = IDX_W'(i);
      if (!valid_q[i])  free_idx    = IDX_W'(i);
    end
  end

  assign hit_now  = |match_now;
  assign any_free = ~&valid_q;
  assign fill_idx = any_free ? free_idx : vict_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q   <= '1;
      valid_q  <= '0;
      pres_q   <= '0;
      dirty_q  <= '0;
      vict_q   <= '0;
      match_q  <= '0;
      off_q    <= '0;
      rvalid_q <= 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i]   <= '0;
        frame_q[i] <= '0;
      end
    end else begin
      if (mask_we) mask_q <= mask_wdata;
      rvalid_q <= lookup_valid;
      match_q  <= lookup_valid ? match_now : '0;
      if (lookup_valid) off_q <= lookup_offset;
      if (lookup_valid && lookup_store && hit_now)
        dirty_q[hit_idx_now] <= 1'b1;
      if (fill_valid) begin
        tag_q[fill_idx]   <= fill_page;
        frame_q[fill_idx] <= fill_frame;
        valid_q[fill_idx] <= 1'b1;
        pres_q[fill_idx]  <= fill_present;
        dirty_q[fill_idx] <= fill_dirty;
        if (!any_free)
          vict_q <= (vict_q == IDX_W'(ENTRIES - 1)) ? '0 : vict_q + 1'b1;
      end
    end
  end

  assign res_valid   = rvalid_q;
  assign res_hit     = rvalid_q && |match_q;
  assign res_walk    = rvalid_q && !(|match_q);
  assign res_index   = res_hit ? win_idx : '0;
  assign res_frame   = res_hit ? frame_q[win_idx] : '0;
  assign res_paddr   = res_hit ? {frame_q[win_idx], off_q} : '0;
  assign res_present = res_hit && pres_q[win_idx];
  assign res_dirty   = res_hit && dirty_q[win_idx];

  assert_result_follows_lookup_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_valid |=> res_valid);
  assert_no_spurious_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lookup_valid |=> !res_valid);
  assert_store_hit_dirty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lookup_valid && lookup_store && hit_now && !fill_valid) |=> (res_hit && res_dirty));
  assert_fill_takes_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && any_free) |=> ($countones(valid_q) == $past($countones(valid_q)) + 1));
  assert_victim_advances_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !any_free) |=> (vict_q != $past(vict_q)));
  assert_miss_walks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lookup_valid && !hit_now) |=> (res_walk && !res_hit));

endmodule

// File: tb/masked_xlat_cam_bench.sv
module masked_xlat_cam_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ENTRIES = 4, PAGE_W = 12, FRAME_W = 10, OFFS_W = 8;
  localparam int IDX_W = 2, PA_W = FRAME_W + OFFS_W;

  logic clk = 0, rst_n = 0;
  logic mask_we = 0, lookup_valid = 0, lookup_store = 0;
  logic fill_valid = 0, fill_present = 0, fill_dirty = 0;
  logic [PAGE_W-1:0] mask_wdata = '0, lookup_page = '0, fill_page = '0;
  logic [OFFS_W-1:0] lookup_offset = '0;
  logic [FRAME_W-1:0] fill_frame = '0;
  logic res_valid, res_hit, res_walk, res_present, res_dirty;
  logic [IDX_W-1:0] res_index;
  logic [FRAME_W-1:0] res_frame;
  logic [PA_W-1:0] res_paddr;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  masked_xlat_cam #(.ENTRIES(ENTRIES), .PAGE_W(PAGE_W), .FRAME_W(FRAME_W), .OFFS_W(OFFS_W))
  u_masked_xlat_cam (
    .clk(clk), .rst_n(rst_n), .mask_we(mask_we), .mask_wdata(mask_wdata),
    .lookup_valid(lookup_valid), .lookup_page(lookup_page), .lookup_offset(lookup_offset),
    .lookup_store(lookup_store), .fill_valid(fill_valid), .fill_page(fill_page),
    .fill_frame(fill_frame), .fill_present(fill_present), .fill_dirty(fill_dirty),
    .res_valid(res_valid), .res_hit(res_hit), .res_walk(res_walk), .res_index(res_index),
    .res_frame(res_frame), .res_paddr(res_paddr), .res_present(res_present), .res_dirty(res_dirty));

  // page, offset, store, hit, index, frame, present, dirty
  localparam logic [35:0] VEC [10] = '{
    {12'h123, 8'h5A, 1'b0, 1'b1, 2'd0, 10'h011, 1'b1, 1'b0},
    {12'h456, 8'h01, 1'b0, 1'b1, 2'd1, 10'h022, 1'b1, 1'b0},
    {12'h789, 8'hFF, 1'b0, 1'b1, 2'd2, 10'h033, 1'b0, 1'b0},
    {12'h120, 8'h10, 1'b0, 1'b1, 2'd3, 10'h044, 1'b1, 1'b1},
    {12'h999, 8'h00, 1'b0, 1'b0, 2'd0, 10'h000, 1'b0, 1'b0},
    {12'h456, 8'h02, 1'b1, 1'b1, 2'd1, 10'h022, 1'b1, 1'b1},
    {12'h456, 8'h03, 1'b0, 1'b1, 2'd1, 10'h022, 1'b1, 1'b1},
    {12'h998, 8'h04, 1'b1, 1'b0, 2'd0, 10'h000, 1'b0, 1'b0},
    {12'h123, 8'h05, 1'b0, 1'b1, 2'd0, 10'h011, 1'b1, 1'b0},
    {12'h789, 8'h06, 1'b1, 1'b1, 2'd2, 10'h033, 1'b0, 1'b1}
  };

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic fill(input logic [PAGE_W-1:0] p, input logic [FRAME_W-1:0] f, input logic pr, input logic d);
    @(negedge clk);
    fill_valid = 1; fill_page = p; fill_frame = f; fill_present = pr; fill_dirty = d;
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic set_mask(input logic [PAGE_W-1:0] m);
    @(negedge clk);
    mask_we = 1; mask_wdata = m;
    @(negedge clk);
    mask_we = 0;
  endtask

  task automatic lk(input string req, input logic [PAGE_W-1:0] p, input logic [OFFS_W-1:0] o,
                    input logic st, input logic eh, input logic [IDX_W-1:0] ei,
                    input logic [FRAME_W-1:0] ef, input logic ep, input logic ed);
    @(negedge clk);
    lookup_valid = 1; lookup_page = p; lookup_offset = o; lookup_store = st;
    @(negedge clk);
    lookup_valid = 0; lookup_store = 0;
    chk(req, "valid", 32'(res_valid), 32'd1);
    chk(req, "hit", 32'(res_hit), 32'(eh));
    chk(req, "walk", 32'(res_walk), 32'(!eh));
    chk(req, "index", 32'(res_index), 32'(ei));
    chk(req, "frame", 32'(res_frame), 32'(ef));
    chk(req, "paddr", 32'(res_paddr), eh ? 32'({ef, o}) : 32'd0);
    chk(req, "present", 32'(res_present), 32'(ep));
    chk(req, "dirty", 32'(res_dirty), 32'(ed));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset valid", 32'(res_valid), 0);
    chk("R1", "reset hit", 32'(res_hit), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R2", "idle valid", 32'(res_valid), 0);
    lk("R1_R5", 12'h123, 8'h11, 0, 0, 0, 0, 0, 0);

    fill(12'h123, 10'h011, 1, 0);
    fill(12'h456, 10'h022, 1, 0);
    fill(12'h789, 10'h033, 0, 0);
    fill(12'h120, 10'h044, 1, 1);

    // R4 R5 R7 R9 R10 vector walk
    for (int i = 0; i < 10; i++) begin
      logic [35:0] v;
      v = VEC[i];
      lk("R4_R7_R9_R10", v[35:24], v[23:16], v[15], v[14], v[13:12], v[11:2], v[1], v[0]);
    end
    @(negedge clk);
    chk("R2", "no result without lookup", 32'(res_valid), 0);

    set_mask(12'hFF0);
    lk("R3_R6", 12'h12F, 8'h21, 0, 1, 0, 10'h011, 1, 0);
    lk("R3", 12'h45A, 8'h22, 0, 1, 1, 10'h022, 1, 1);
    set_mask(12'h00F);
    lk("R3", 12'hFF3, 8'h23, 0, 1, 0, 10'h011, 1, 0);
    lk("R3_R6", 12'hAB0, 8'h24, 0, 1, 3, 10'h044, 1, 1);
    set_mask(12'hFFF);
    lk("R3", 12'h12F, 8'h25, 0, 0, 0, 0, 0, 0);

    fill(12'hAAA, 10'h055, 1, 0);
    lk("R8", 12'hAAA, 8'h31, 0, 1, 0, 10'h055, 1, 0);
    lk("R8", 12'h123, 8'h32, 0, 0, 0, 0, 0, 0);
    fill(12'hBBB, 10'h066, 0, 1);
    lk("R8", 12'hBBB, 8'h33, 0, 1, 1, 10'h066, 0, 1);
    lk("R8", 12'h456, 8'h34, 0, 0, 0, 0, 0, 0);
    lk("R8", 12'h789, 8'h35, 0, 1, 2, 10'h033, 0, 1);

    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    lk("R1", 12'hBBB, 8'h41, 0, 0, 0, 0, 0, 0);
    fill(12'h100, 10'h077, 1, 0);
    lk("R1_R7", 12'h100, 8'h42, 0, 1, 0, 10'h077, 1, 0);
    lk("R1", 12'h101, 8'h43, 0, 0, 0, 0, 0, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule